// File: doc/BRIEF.md
# ARINC 429 Word Transmitter

This block turns a 32-bit ARINC 429 word, handed over by a host as four bytes, into the return-to-zero line code on two rails: one rail pulses for a logic 1, the other pulses for a logic 0, and both low is the null level. It runs from a single clock at four times the line bit rate. Each bit cell is four clocks: the active rail is high for the first two and both rails are null for the last two. After every word, the rails stay null for at least four bit times before the next word may begin.

Bytes enter through a valid/ready stream. A byte transfers on a clock edge where `byte_valid` and `byte_ready` are both high. The host may hold `byte_valid` high with stable data for as long as it likes, and the block takes the byte only when it raises `byte_ready`. In word mode the host loads all four bytes before the word is released. In byte mode the host loads the first byte, and then feeds each later byte while the word is already on the line. If a byte comes too late, the word is cut short and an underwrite error is raised. Bit 32 can be replaced by a generated odd-parity bit.

A word is released only while the enable control is high, clear-to-send is low, and no error is pending. A short low pulse on clear-to-send therefore releases exactly one word. In loopback mode the external rails stay null and the stream appears on a separate pair of internal rails meant for a receiver.

Top module: `a429_word_tx`

## Requirements
- R1: Each transmitted bit is a 4-clock cell. `line_one` is high for 2 clocks for a 1, or `line_zero` is high for 2 clocks for a 0, followed by 2 clocks with both rails low. The two rails are never high together.
- R2: Word bit n (n = 1..32) is bit (n-1) mod 8 of byte number (n-1)/8, counting in load order from byte 0. Bits leave in the order n = 1, 2, ..., 32.
- R3: With `parity_en` = 1, bit 32 is sent as the value that makes the number of ones among all 32 bits odd. With `parity_en` = 0, bit 32 is bit 7 of the fourth byte.
- R4: Word mode (`byte_mode` = 0): a word starts only once four bytes are held. `byte_ready` is high while idle with fewer than four bytes held, and low while a word is being sent.
- R5: Byte mode (`byte_mode` = 1): a word may start with one byte held. While idle, `byte_ready` is high only when no byte is held. While sending, `byte_ready` is high only when the byte that follows the one currently on the line has not been loaded yet, and it drops after that byte is taken.
- R6: In byte mode, if the next byte is not held by the last clock of the current byte's eighth bit cell, `underwrite_err` rises, the word stops after that bit, and the rails stay null.
- R7: A word starts only while `tx_en` = 1, `cts_n` = 0 and no error is pending. With `cts_n` high, or with `tx_en` low, a loaded word stays unsent. Raising `tx_en` with a loaded buffer and `cts_n` low starts the word.
- R8: `tx_idle` is low from the start of a word through its last bit cell, and high at all other times.
- R9: Between the end of one word's last pulse and the first pulse of the next word, the rails are null for at least 16 clocks (four bit times).
- R10: A pending error keeps `byte_ready` low and blocks every start until a one-clock `status_rd` pulse clears it, or until reset.
- R11: With `loopback` = 1, `line_one` and `line_zero` stay low, and the same stream appears on `lb_one` and `lb_zero`.
- R12: After reset the rails are low, `tx_idle` = 1, `byte_ready` = 1 and `underwrite_err` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at four times the bit rate |
| rst | input | 1 | Synchronous reset, active high |
| tx_en | input | 1 | Transmitter enable control bit |
| cts_n | input | 1 | Clear-to-send, active low |
| byte_mode | input | 1 | 1: byte-at-a-time loading; 0: whole-word loading |
| parity_en | input | 1 | 1: bit 32 carries generated odd parity |
| loopback | input | 1 | 1: hold external rails null and drive the internal rails |
| status_rd | input | 1 | One-clock pulse that clears a pending error |
| byte_valid | input | 1 | Stream valid for `byte_data` |
| byte_data | input | 8 | Next byte of the word |
| byte_ready | output | 1 | Stream ready; the block can take a byte |
| line_one | output | 1 | External ones rail |
| line_zero | output | 1 | External zeros rail |
| lb_one | output | 1 | Internal ones rail in loopback |
| lb_zero | output | 1 | Internal zeros rail in loopback |
| tx_idle | output | 1 | High when no word is on the line |
| underwrite_err | output | 1 | Late byte in byte mode |

## Verification
The bench builds the block with its default parameters. These are a 4-clock cell with 2 high clocks, 32-bit words of four 8-bit lanes, and a 4-bit-time gap. With these values a full word takes 128 clocks, so many words fit in a short run. The bench uses these settings to exercise several things:
- back-to-back words with the inter-word gap;
- on-the-fly loading that keeps one byte ahead of the line;
- an underwrite at the end of the first byte;
- words whose 31 data bits have both even and odd ones counts, to test the parity bit.

// File: rtl/a429tx_pkg.sv
package a429tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_GAP  = 2'd2
  } tx_state_t;
endpackage

// File: rtl/a429tx_lanes.sv
module a429tx_lanes
  import a429tx_pkg::*;
#(
  parameter int LANE_BITS = 8,
  parameter int LANES     = 4,
  localparam int CW = $clog2(LANES + 1),
  localparam int LW = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_valid,
  input  logic [LANE_BITS-1:0]       wr_data,
  output logic                       wr_ready,
  input  logic                       clr,
  input  logic                       sending,
  input  logic                       byte_mode,
  input  logic [LW-1:0]              cur_lane,
  input  logic                       err,
  output logic [LANES*LANE_BITS-1:0] lanes_flat,
  output logic [CW-1:0]              fill
);
  logic wr_fire;
  logic [CW-1:0] next_slot;

  assign next_slot = CW'(cur_lane) + CW'(1);

  always_comb begin
    if (err)            wr_ready = 1'b0;
    else if (!byte_mode) wr_ready = !sending && (fill < CW'(LANES));
    else if (sending)   wr_ready = (fill < CW'(LANES)) && (fill == next_slot);
    else                wr_ready = (fill == '0);
  end

  assign wr_fire = wr_valid && wr_ready;

  always_ff @(posedge clk) begin
    if (rst)          fill <= '0;
    else if (clr)     fill <= '0;
    else if (wr_fire) fill <= fill + CW'(1);
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_BITS-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (rst)                               lane_q <= '0;
      else if (wr_fire && fill == CW'(g))    lane_q <= wr_data;
    end
    assign lanes_flat[g*LANE_BITS +: LANE_BITS] = lane_q;
  end

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (rst) fill <= CW'(LANES)); // R4
  AST_LOAD_DROPS_READY: assert property (@(posedge clk) disable iff (rst) (byte_mode && wr_fire && !clr && !sending) |=> (!byte_mode || !wr_ready)); // R5
endmodule

// File: rtl/a429tx_seq.sv
module a429tx_seq
  import a429tx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 4,
  parameter int PULSE_CLKS      = 2,
  parameter int WORD_BITS       = 32,
  parameter int LANE_BITS       = 8,
  parameter int GAP_BITS        = 4,
  localparam int LANES    = WORD_BITS / LANE_BITS,
  localparam int CW       = $clog2(LANES + 1),
  localparam int LW       = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int PW       = $clog2(SAMPLES_PER_BIT),
  localparam int BW       = $clog2(WORD_BITS),
  localparam int GAP_CLKS = GAP_BITS * SAMPLES_PER_BIT,
  localparam int GW       = $clog2(GAP_CLKS + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_en,
  input  logic                 cts_n,
  input  logic                 byte_mode,
  input  logic                 parity_en,
  input  logic                 status_rd,
  input  logic [CW-1:0]        fill,
  input  logic [WORD_BITS-1:0] lanes_flat,
  output tx_state_t            state,
  output logic [LW-1:0]        cur_lane,
  output logic                 bit_val,
  output logic                 cell_hi,
  output logic                 clr,
  output logic                 err
);
  logic [PW-1:0] phase;
  logic [BW-1:0] bit_idx;
  logic [BW-1:0] lane_pos;
  logic [GW-1:0] gap_cnt;
  logic          par_acc;
  logic          cell_end, last_bit, lane_end, enough, go, underrun;

  assign cur_lane = LW'(bit_idx / BW'(LANE_BITS));
  assign lane_pos = bit_idx % BW'(LANE_BITS);
  assign lane_end = (lane_pos == BW'(LANE_BITS - 1));
  assign last_bit = (bit_idx == BW'(WORD_BITS - 1));
  assign cell_end = (phase == PW'(SAMPLES_PER_BIT - 1));
  assign bit_val  = (last_bit && parity_en) ? ~par_acc : lanes_flat[bit_idx];
  assign cell_hi  = (state == ST_SEND) && (phase < PW'(PULSE_CLKS));
  assign enough   = byte_mode ? (fill != '0) : (fill == CW'(LANES));
  assign go       = (state == ST_IDLE) && tx_en && !cts_n && !err && enough;
  assign underrun = byte_mode && lane_end && !last_bit &&
                    (fill <= CW'(cur_lane) + CW'(1));
  assign clr      = (state == ST_SEND) && cell_end && (last_bit || underrun);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      phase   <= '0;
      bit_idx <= '0;
      gap_cnt <= '0;
      par_acc <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (status_rd) err <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (go) begin
            state   <= ST_SEND;
            phase   <= '0;
            bit_idx <= '0;
            par_acc <= 1'b0;
          end
        end
        ST_SEND: begin
          phase <= phase + PW'(1);
          if (cell_end) begin
            par_acc <= par_acc ^ bit_val;
            phase   <= '0;
            if (underrun || last_bit) begin
              state   <= ST_GAP;
              gap_cnt <= GW'(GAP_CLKS);
              if (underrun) err <= 1'b1;
            end else begin
              bit_idx <= bit_idx + BW'(1);
            end
          end
        end
        ST_GAP: begin
          gap_cnt <= gap_cnt - GW'(1);
          if (gap_cnt <= GW'(1)) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  AST_ERR_HOLDS: assert property (@(posedge clk) disable iff (rst) (err && !status_rd) |=> err); // R10
  AST_NO_START_ON_ERR: assert property (@(posedge clk) disable iff (rst) (state == ST_IDLE && err) |=> state != ST_SEND); // R10
  AST_GAP_NOT_SEND: assert property (@(posedge clk) disable iff (rst) (state == ST_GAP) |=> state != ST_SEND); // R9
  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (rst) $rose(err) |-> state == ST_GAP); // R6
endmodule

// File: rtl/a429tx_rails.sv
module a429tx_rails #(
  parameter int PULSE_CLKS = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cell_hi,
  input  logic bit_val,
  input  logic loopback,
  output logic line_one,
  output logic line_zero,
  output logic lb_one,
  output logic lb_zero
);
  logic one_q, zero_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      one_q  <= 1'b0;
      zero_q <= 1'b0;
    end else begin
      one_q  <= cell_hi && bit_val;
      zero_q <= cell_hi && !bit_val;
    end
  end

  assign line_one  = one_q  && !loopback;
  assign line_zero = zero_q && !loopback;
  assign lb_one    = one_q  && loopback;
  assign lb_zero   = zero_q && loopback;

  if (PULSE_CLKS == 2) begin : g_pulse_chk
    AST_PULSE_MIN: assert property (@(posedge clk) disable iff (rst) $rose(one_q) |=> one_q); // R1
    AST_PULSE_MAX: assert property (@(posedge clk) disable iff (rst) (one_q && $past(one_q)) |=> !one_q); // R1
  end
endmodule

// File: rtl/a429_word_tx.sv
module a429_word_tx
  import a429tx_pkg::*;
#(
  parameter int SAMPLES_PER_BIT = 4,
  parameter int PULSE_CLKS      = 2,
  parameter int WORD_BITS       = 32,
  parameter int LANE_BITS       = 8,
  parameter int GAP_BITS        = 4,
  localparam int LANES = WORD_BITS / LANE_BITS,
  localparam int CW    = $clog2(LANES + 1),
  localparam int LW    = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 tx_en,
  input  logic                 cts_n,
  input  logic                 byte_mode,
  input  logic                 parity_en,
  input  logic                 loopback,
  input  logic                 status_rd,
  input  logic                 byte_valid,
  input  logic [LANE_BITS-1:0] byte_data,
  output logic                 byte_ready,
  output logic                 line_one,
  output logic                 line_zero,
  output logic                 lb_one,
  output logic                 lb_zero,
  output logic                 tx_idle,
  output logic                 underwrite_err
);
  tx_state_t            state;
  logic [LW-1:0]        cur_lane;
  logic [CW-1:0]        fill;
  logic [WORD_BITS-1:0] lanes_flat;
  logic                 bit_val, cell_hi, clr, err, sending;

  assign sending        = (state == ST_SEND);
  assign tx_idle        = !sending;
  assign underwrite_err = err;

  a429tx_lanes #(.LANE_BITS(LANE_BITS), .LANES(LANES)) i_lanes (
    .clk(clk), .rst(rst), .wr_valid(byte_valid), .wr_data(byte_data),
    .wr_ready(byte_ready), .clr(clr), .sending(sending), .byte_mode(byte_mode),
    .cur_lane(cur_lane), .err(err), .lanes_flat(lanes_flat), .fill(fill)
  );

  a429tx_seq #(
    .SAMPLES_PER_BIT(SAMPLES_PER_BIT), .PULSE_CLKS(PULSE_CLKS),
    .WORD_BITS(WORD_BITS), .LANE_BITS(LANE_BITS), .GAP_BITS(GAP_BITS)
  ) i_seq (
    .clk(clk), .rst(rst), .tx_en(tx_en), .cts_n(cts_n), .byte_mode(byte_mode),
    .parity_en(parity_en), .status_rd(status_rd), .fill(fill),
    .lanes_flat(lanes_flat), .state(state), .cur_lane(cur_lane),
    .bit_val(bit_val), .cell_hi(cell_hi), .clr(clr), .err(err)
  );

  a429tx_rails #(.PULSE_CLKS(PULSE_CLKS)) i_rails (
    .clk(clk), .rst(rst), .cell_hi(cell_hi), .bit_val(bit_val),
    .loopback(loopback), .line_one(line_one), .line_zero(line_zero),
    .lb_one(lb_one), .lb_zero(lb_zero)
  );

  AST_READY_LOW_ON_ERR: assert property (@(posedge clk) disable iff (rst) underwrite_err |-> !byte_ready); // R10
  AST_WORD_MODE_BUSY: assert property (@(posedge clk) disable iff (rst) (!byte_mode && !tx_idle) |-> !byte_ready); // R4
endmodule

// File: tb/test_a429_word_tx.sv
module a429_line_mon (
  input logic clk,
  input logic one,
  input logic zero
);
  int          total = 0;
  logic [31:0] sr = '0;
  int          width_err = 0;
  int          both_err = 0;
  int          null_run = 1000;
  int          hi_run = 0;
  int          gap_at [256];
  logic        prev_hi = 1'b0;

  always @(negedge clk) begin
    if (one && zero) both_err++;
    if ((one || zero) && !prev_hi) begin
      sr = {one, sr[31:1]};
      gap_at[total % 256] = null_run;
      total++;
      hi_run = 1;
    end else if (one || zero) begin
      hi_run++;
    end else begin
      if (prev_hi && hi_run != 2) width_err++;
      null_run = prev_hi ? 1 : null_run + 1;
    end
    prev_hi = one || zero;
  end
endmodule

module test_a429_word_tx;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tx_en = 1'b0, cts_n = 1'b1, byte_mode = 1'b0, parity_en = 1'b0;
  logic loopback = 1'b0, status_rd = 1'b0, byte_valid = 1'b0;
  logic [7:0] byte_data = '0;
  logic byte_ready, line_one, line_zero, lb_one, lb_zero, tx_idle, underwrite_err;

  int n_chk = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  a429_word_tx i_a429_word_tx (
    .clk(clk), .rst(rst), .tx_en(tx_en), .cts_n(cts_n), .byte_mode(byte_mode),
    .parity_en(parity_en), .loopback(loopback), .status_rd(status_rd),
    .byte_valid(byte_valid), .byte_data(byte_data), .byte_ready(byte_ready),
    .line_one(line_one), .line_zero(line_zero), .lb_one(lb_one), .lb_zero(lb_zero),
    .tx_idle(tx_idle), .underwrite_err(underwrite_err)
  );

  a429_line_mon i_mon_ext (.clk(clk), .one(line_one), .zero(line_zero));
  a429_line_mon i_mon_lb  (.clk(clk), .one(lb_one),   .zero(lb_zero));

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    while (!byte_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic wait_ext(input int target);
    for (int i = 0; i < 2000 && i_mon_ext.total < target; i++) @(negedge clk);
    repeat (6) @(negedge clk);
  endtask

  function automatic logic [31:0] expect_word(input logic [31:0] w, input bit par);
    return par ? {~(^w[30:0]), w[30:0]} : w;
  endfunction

  task automatic send_word32(input logic [31:0] w, input bit par, input string req);
    int base;
    base = i_mon_ext.total;
    parity_en = par;
    byte_mode = 1'b0;
    tx_en = 1'b1;
    for (int k = 0; k < 4; k++) push(w[k*8 +: 8]);
    @(negedge clk);
    cts_n = 1'b0;
    repeat (40) @(negedge clk);
    chk(byte_ready == 1'b0, "R4 ready low while sending", 32'(byte_ready), 0);
    wait_ext(base + 32);
    cts_n = 1'b1;
    chk(i_mon_ext.total == base + 32, req, i_mon_ext.total - base, 32);
    chk(i_mon_ext.sr == expect_word(w, par), req, i_mon_ext.sr, expect_word(w, par));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(line_one == 0 && line_zero == 0, "R12 rails null", {line_one, line_zero}, 0);
    chk(tx_idle == 1, "R12 idle", 32'(tx_idle), 1);
    chk(byte_ready == 1, "R12 ready", 32'(byte_ready), 1);
    chk(underwrite_err == 0, "R12 no error", 32'(underwrite_err), 0);
  endtask

  task automatic t_gate_and_busy;
    int base;
    base = i_mon_ext.total;
    byte_mode = 1'b0; parity_en = 1'b0; tx_en = 1'b1; cts_n = 1'b1;
    push(8'hA5); push(8'h3C); push(8'h0F); push(8'h81);
    chk(byte_ready == 0, "R4 ready low with four bytes", 32'(byte_ready), 0);
    repeat (60) @(negedge clk);
    chk(i_mon_ext.total == base && tx_idle == 1, "R7 held by cts_n", i_mon_ext.total - base, 0);
    tx_en = 1'b0; cts_n = 1'b0;
    repeat (60) @(negedge clk);
    chk(i_mon_ext.total == base, "R7 held by tx_en", i_mon_ext.total - base, 0);
    tx_en = 1'b1;
    repeat (4) @(negedge clk);
    chk(tx_idle == 0, "R8 busy after start", 32'(tx_idle), 0);
    repeat (3) @(negedge clk);
    cts_n = 1'b1;
    wait_ext(base + 32);
    chk(tx_idle == 1, "R8 idle after word", 32'(tx_idle), 1);
    chk(i_mon_ext.sr == 32'h810F3CA5, "R2 bit order", i_mon_ext.sr, 32'h810F3CA5);
    chk(i_mon_ext.total == base + 32, "R7 one word per cts pulse", i_mon_ext.total - base, 32);
    repeat (200) @(negedge clk);
    chk(i_mon_ext.total == base + 32, "R7 no second word", i_mon_ext.total - base, 32);
  endtask

  task automatic t_parity;
    send_word32(32'h7000_0001, 1'b1, "R3 parity even data");
    send_word32(32'h7000_0003, 1'b1, "R3 parity odd data");
    send_word32(32'h0123_4567, 1'b0, "R3 data in bit 32");
  endtask

  task automatic t_byte_mode;
    int base;
    logic [31:0] w;
    w = 32'h5A_C3_96_E1;
    base = i_mon_ext.total;
    byte_mode = 1'b1; parity_en = 1'b1; tx_en = 1'b1; cts_n = 1'b1;
    push(w[7:0]);
    chk(byte_ready == 0, "R5 ready low after first byte", 32'(byte_ready), 0);
    cts_n = 1'b0;
    push(w[15:8]);
    @(negedge clk);
    chk(byte_ready == 0, "R5 ready low one byte ahead", 32'(byte_ready), 0);
    push(w[23:16]);
    push(w[31:24]);
    cts_n = 1'b1;
    wait_ext(base + 32);
    chk(underwrite_err == 0, "R5 no underwrite when fed in time", 32'(underwrite_err), 0);
    chk(i_mon_ext.sr == expect_word(w, 1'b1), "R5 on-the-fly word", i_mon_ext.sr, expect_word(w, 1'b1));
  endtask

  task automatic t_underwrite;
    int base;
    base = i_mon_ext.total;
    byte_mode = 1'b1; parity_en = 1'b0; tx_en = 1'b1; cts_n = 1'b1;
    push(8'h6B);
    cts_n = 1'b0;
    wait_ext(base + 8);
    repeat (10) @(negedge clk);
    chk(underwrite_err == 1, "R6 error raised", 32'(underwrite_err), 1);
    chk(i_mon_ext.total == base + 8, "R6 word cut after byte", i_mon_ext.total - base, 8);
    chk(i_mon_ext.sr[31:24] == 8'h6B, "R6 first byte sent", 32'(i_mon_ext.sr[31:24]), 32'h6B);
    chk(tx_idle == 1 && line_one == 0 && line_zero == 0, "R6 rails null", {tx_idle, line_one, line_zero}, 32'h4);
    chk(byte_ready == 0, "R10 ready low on error", 32'(byte_ready), 0);
    repeat (150) @(negedge clk);
    chk(i_mon_ext.total == base + 8 && underwrite_err == 1, "R10 stopped until cleared", i_mon_ext.total - base, 8);
    cts_n = 1'b1;
    status_rd = 1'b1;
    @(negedge clk);
    status_rd = 1'b0;
    @(negedge clk);
    chk(underwrite_err == 0, "R10 cleared by status read", 32'(underwrite_err), 0);
    chk(byte_ready == 1, "R10 ready back", 32'(byte_ready), 1);
  endtask

  task automatic t_gap;
    int base;
    base = i_mon_ext.total;
    byte_mode = 1'b0; parity_en = 1'b0; tx_en = 1'b1; cts_n = 1'b1;
    push(8'h11); push(8'h22); push(8'h33); push(8'h44);
    cts_n = 1'b0;
    push(8'hEE); push(8'hDD); push(8'hCC); push(8'hBB);
    wait_ext(base + 64);
    cts_n = 1'b1;
    chk(i_mon_ext.total == base + 64, "R9 two words sent", i_mon_ext.total - base, 64);
    chk(i_mon_ext.sr == 32'hBBCCDDEE, "R9 second word intact", i_mon_ext.sr, 32'hBBCCDDEE);
    chk(i_mon_ext.gap_at[(base + 32) % 256] >= 16, "R9 inter-word null", i_mon_ext.gap_at[(base + 32) % 256], 16);
  endtask

  task automatic t_loopback;
    int base_e, base_l;
    base_e = i_mon_ext.total;
    base_l = i_mon_lb.total;
    loopback = 1'b1;
    byte_mode = 1'b0; parity_en = 1'b1; tx_en = 1'b1; cts_n = 1'b1;
    push(8'h9C); push(8'h00); push(8'hFF); push(8'h12);
    cts_n = 1'b0;
    repeat (10) @(negedge clk);
    cts_n = 1'b1;
    for (int i = 0; i < 2000 && i_mon_lb.total < base_l + 32; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(i_mon_ext.total == base_e, "R11 external rails null", i_mon_ext.total - base_e, 0);
    chk(i_mon_lb.total == base_l + 32, "R11 internal stream count", i_mon_lb.total - base_l, 32);
    chk(i_mon_lb.sr == expect_word(32'h12FF009C, 1'b1), "R11 internal stream data", i_mon_lb.sr, expect_word(32'h12FF009C, 1'b1));
    loopback = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: run hung actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_gate_and_busy();
    t_parity();
    t_byte_mode();
    t_underwrite();
    t_gap();
    t_loopback();
    chk(i_mon_ext.width_err == 0 && i_mon_lb.width_err == 0, "R1 pulse width two clocks",
        i_mon_ext.width_err + i_mon_lb.width_err, 0);
    chk(i_mon_ext.both_err == 0 && i_mon_lb.both_err == 0, "R1 rails exclusive",
        i_mon_ext.both_err + i_mon_lb.both_err, 0);
    chk(i_mon_ext.gap_at[1] <= 2, "R1 null half of cell", i_mon_ext.gap_at[1], 2);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule